// File: doc/BRIEF.md
# SONET Receive Framer and Monitor

This block takes an already byte-aligned SONET/SDH receive stream and works out where each frame begins. A clock-enable qualifies every byte. While the block has no frame alignment, it hunts for the framing pair. It confirms alignment only when the pair recurs one frame later. Once aligned, it tracks the row and column of every byte. It reports out-of-frame when the framing pair keeps failing. It escalates to loss-of-frame when the out-of-frame state lasts too long.

While aligned, the block descrambles each byte with the frame-synchronous sequence and hands it downstream with its row, column and a frame-start marker. It also checks the section parity byte against a BIP-8 taken over the previous scrambled frame. The number of mismatched bits goes into a saturating counter that can be cleared. The section trace byte is compared with a programmed value, and a flag is raised when it stays wrong.

The frame geometry is set by parameters: `ROWS` rows of `COLS` bytes. There is one framing pair at row 0, columns 0 and 1. The trace byte sits at row 0, column 2, and the parity byte at row 1, column 0.

Top module: `sonet_rx_framer`

## Requirements
- R1: After reset, `oof` is 1, `lof` is 0, `j0_mismatch` is 0, `b1_err_cnt` is 0 and `dout_valid` is 0.
- R2: In the hunting state, byte 0xF6 followed by byte 0x28 marks a candidate. The next byte is taken as row 0, column 2. `oof` falls only when 0xF6/0x28 is seen again at row 0, columns 0/1, exactly `ROWS*COLS` valid bytes later. A single pattern leaves `oof` at 1.
- R3: A cycle with `din_valid` low is ignored. It advances no position, window or sequence.
- R4: While in frame, each byte leaves on `dout` one clock later, with `dout_valid`=1, its `dout_row`/`dout_col`, and `dout_sof`=1 at row 0, column 0. Row 0, columns 0..2 pass unchanged. Every other byte is XORed with the x^7+x^6+1 sequence, MSB first. The sequence is loaded with all ones for row 0, column 3, so that byte's key is 0xFE. `dout_valid` is 0 whenever `oof` was 1.
- R5: While in frame, four consecutive frames with a wrong byte at row 0, column 0 or 1 raise `oof` at the fourth. Three, or a run broken by one good frame, keep `oof` at 0.
- R6: `lof` rises when `oof` has stayed 1 for `LOF_FRAMES*ROWS*COLS` valid bytes. It falls when in-frame is declared again. `lof`=1 implies `oof`=1.
- R7: The BIP-8 (bitwise XOR) of all scrambled bytes of one complete in-frame frame is compared with the descrambled byte at row 1, column 0 of the next frame. The number of differing bits is added to `b1_err_cnt`.
- R8: `b1_err_cnt` saturates at 2^`CNT_W`-1. A pulse on `b1_cnt_clr` sets it to 0, and the clear wins over a same-cycle update.
- R9: `j0_mismatch` rises when the byte at row 0, column 2 differs from `cfg_j0_expect` in three consecutive in-frame frames. Two such frames do not raise it. It falls at the first matching frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_valid | input | 1 | Byte enable for `din` |
| din | input | 8 | Received byte, still scrambled |
| cfg_j0_expect | input | 8 | Expected section trace byte |
| b1_cnt_clr | input | 1 | Clears the parity error counter |
| dout_valid | output | 1 | Output byte valid (in frame) |
| dout | output | 8 | Descrambled byte |
| dout_row | output | $clog2(ROWS) | Row of `dout` |
| dout_col | output | $clog2(COLS) | Column of `dout` |
| dout_sof | output | 1 | Marks row 0, column 0 |
| oof | output | 1 | Out-of-frame |
| lof | output | 1 | Loss-of-frame |
| j0_mismatch | output | 1 | Persistent trace mismatch |
| b1_err_cnt | output | CNT_W | Saturating parity bit error count |

## Verification
The stream starts with idle filler and then a single framing pattern. This shows that one pattern alone leaves the block out of frame and that the recurrence one frame later brings it in frame. Clean frames with idle gaps inserted at random are checked byte by byte against an independent scrambler and BIP model. That run separates correct key seeding and position tracking from off-by-one errors. Framing faults are injected in runs of three, in runs broken by one good frame, and in runs of four, to pin down the exact out-of-frame threshold. Zero filler then counts out the loss-of-frame window to within one byte. Parity bytes carry chosen bit masks, and trace bytes go wrong for two and then three frames, to exercise the counter, its saturation and clear, and the trace flag.

// File: rtl/sonet_rx_pkg.sv
package sonet_rx_pkg;
  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;
  localparam int         J0_COL  = 2;
  localparam int         OOF_BAD = 4;

  typedef enum logic [1:0] {ST_HUNT, ST_PRESYNC, ST_SYNC} frm_state_e;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/sonet_rx_align.sv
module sonet_rx_align import sonet_rx_pkg::*; #(
  parameter int ROWS       = 9,
  parameter int COLS       = 90,
  parameter int LOF_FRAMES = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [7:0]                din,
  output frm_state_e                st,
  output logic [$clog2(ROWS)-1:0]   row,
  output logic [$clog2(COLS)-1:0]   col,
  output logic                      oof,
  output logic                      lof
);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(COLS);
  localparam int LOF_BYTES = LOF_FRAMES * ROWS * COLS;
  localparam int LOF_W     = $clog2(LOF_BYTES);
  localparam logic [1:0] BAD_LIM = 2'(OOF_BAD - 1);

  frm_state_e       st_nxt;
  logic             prev_a1, a1_seen, pat_ok, at_a1, at_a2;
  logic [1:0]       bad_cnt;
  logic [LOF_W-1:0] lof_cnt;

  assign at_a1  = (row == '0) && (col == '0);
  assign at_a2  = (row == '0) && (col == COL_W'(1));
  assign pat_ok = a1_seen && (din == A2_BYTE);
  assign oof    = (st != ST_SYNC);

  always_comb begin
    st_nxt = st;
    if (st == ST_HUNT) begin
      if (prev_a1 && din == A2_BYTE) st_nxt = ST_PRESYNC;
    end else if (at_a2) begin
      if (st == ST_PRESYNC)                  st_nxt = pat_ok ? ST_SYNC : ST_HUNT;
      else if (!pat_ok && bad_cnt == BAD_LIM) st_nxt = ST_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      prev_a1 <= 1'b0;
      a1_seen <= 1'b0;
      bad_cnt <= '0;
      row     <= '0;
      col     <= '0;
      lof_cnt <= '0;
      lof     <= 1'b0;
    end else if (en) begin
      st      <= st_nxt;
      prev_a1 <= (din == A1_BYTE);
      if (st == ST_HUNT) begin
        if (st_nxt == ST_PRESYNC) begin
          row <= '0;
          col <= COL_W'(J0_COL);
        end
      end else begin
        if (col == COL_W'(COLS - 1)) begin
          col <= '0;
          row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
        if (at_a1) a1_seen <= (din == A1_BYTE);
      end
      if (st == ST_SYNC && at_a2)
        bad_cnt <= (pat_ok || bad_cnt == BAD_LIM) ? '0 : bad_cnt + 1'b1;
      else if (st != ST_SYNC)
        bad_cnt <= '0;
      if (st_nxt == ST_SYNC) begin
        lof_cnt <= '0;
        lof     <= 1'b0;
      end else if (st != ST_SYNC) begin
        if (lof_cnt == LOF_W'(LOF_BYTES - 1)) lof <= 1'b1;
        else                                  lof_cnt <= lof_cnt + 1'b1;
      end
    end
  end

  // R2: a hunt can never jump straight into frame
  p_no_direct_sync_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HUNT) |=> (st != ST_SYNC));
  // R5: fewer than four errored patterns keep the frame
  p_oof_needs_four_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SYNC && bad_cnt != BAD_LIM) |=> (st == ST_SYNC));
  // R6: loss of frame only while out of frame
  p_lof_implies_oof_r6: assert property (@(posedge clk) disable iff (rst)
    lof |-> oof);
endmodule

// File: rtl/sonet_rx_descr.sv
module sonet_rx_descr import sonet_rx_pkg::*; #(
  parameter int ROWS = 9,
  parameter int COLS = 90
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    track,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [$clog2(COLS)-1:0] col,
  input  logic [7:0]              din,
  output logic [7:0]              dbyte
);
  localparam int COL_W = $clog2(COLS);

  logic [6:0] lfsr, s, adv;
  logic [7:0] key;
  logic       clear_zone;

  always_comb begin
    s = lfsr;
    key = '0;
    for (int i = 7; i >= 0; i--) begin
      key[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    adv = s;
  end

  assign clear_zone = (row == '0) && (col <= COL_W'(J0_COL));
  assign dbyte      = clear_zone ? din : (din ^ key);

  always_ff @(posedge clk) begin
    if (rst)                                             lfsr <= '1;
    else if (en && row == '0 && col == COL_W'(J0_COL))   lfsr <= '1;
    else if (en)                                         lfsr <= adv;
  end

  // R4: first scrambled byte of a frame uses key 0xFE
  p_seed_key_r4: assert property (@(posedge clk) disable iff (rst)
    (en && track && row == '0 && col == COL_W'(J0_COL + 1)) |-> (key == 8'hFE));
endmodule

// File: rtl/sonet_rx_bip.sv
module sonet_rx_bip import sonet_rx_pkg::*; #(
  parameter int ROWS  = 9,
  parameter int COLS  = 90,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    track,
  input  logic                    sync,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [$clog2(COLS)-1:0] col,
  input  logic [7:0]              raw,
  input  logic [7:0]              dbyte,
  input  logic                    clr,
  output logic [CNT_W-1:0]        cnt
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]     acc, prev_bip;
  logic           acc_full, bip_ok, at_b1;
  logic [3:0]     errs;
  logic [CNT_W:0] sum;

  assign at_b1 = en && sync && bip_ok && (row == ROW_W'(1)) && (col == '0);
  assign errs  = ones8(dbyte ^ prev_bip);
  assign sum   = {1'b0, cnt} + (CNT_W + 1)'(errs);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      prev_bip <= '0;
      acc_full <= 1'b0;
      bip_ok   <= 1'b0;
    end else if (en) begin
      if (!track) begin
        acc_full <= 1'b0;
        bip_ok   <= 1'b0;
      end else if (row == '0 && col == '0) begin
        prev_bip <= acc;
        acc      <= raw;
        acc_full <= 1'b1;
        bip_ok   <= acc_full;
      end else begin
        acc <= acc ^ raw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (at_b1)   cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  // R8: clear wins and zeroes the count
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R8: a full counter stays full
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
  // R7: count moves only at the parity byte of an in-frame frame
  p_b1_only_r7: assert property (@(posedge clk) disable iff (rst)
    (!at_b1 && !clr) |=> $stable(cnt));
endmodule

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer import sonet_rx_pkg::*; #(
  parameter int ROWS       = 9,
  parameter int COLS       = 90,
  parameter int LOF_FRAMES = 24,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    din_valid,
  input  logic [7:0]              din,
  input  logic [7:0]              cfg_j0_expect,
  input  logic                    b1_cnt_clr,
  output logic                    dout_valid,
  output logic [7:0]              dout,
  output logic [$clog2(ROWS)-1:0] dout_row,
  output logic [$clog2(COLS)-1:0] dout_col,
  output logic                    dout_sof,
  output logic                    oof,
  output logic                    lof,
  output logic                    j0_mismatch,
  output logic [CNT_W-1:0]        b1_err_cnt
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  frm_state_e       st;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [7:0]       dbyte;
  logic [1:0]       j0_cnt;
  logic             track, sync, at_j0;

  assign track = (st != ST_HUNT);
  assign sync  = (st == ST_SYNC);
  assign at_j0 = din_valid && sync && (row == '0) && (col == COL_W'(J0_COL));

  sonet_rx_align #(.ROWS(ROWS), .COLS(COLS), .LOF_FRAMES(LOF_FRAMES)) u_align (
    .clk(clk), .rst(rst), .en(din_valid), .din(din),
    .st(st), .row(row), .col(col), .oof(oof), .lof(lof));

  sonet_rx_descr #(.ROWS(ROWS), .COLS(COLS)) u_descr (
    .clk(clk), .rst(rst), .en(din_valid), .track(track),
    .row(row), .col(col), .din(din), .dbyte(dbyte));

  sonet_rx_bip #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_bip (
    .clk(clk), .rst(rst), .en(din_valid), .track(track), .sync(sync),
    .row(row), .col(col), .raw(din), .dbyte(dbyte),
    .clr(b1_cnt_clr), .cnt(b1_err_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      j0_cnt      <= '0;
      j0_mismatch <= 1'b0;
    end else if (at_j0) begin
      if (din != cfg_j0_expect) begin
        if (j0_cnt == 2'd2) j0_mismatch <= 1'b1;
        else                j0_cnt      <= j0_cnt + 1'b1;
      end else begin
        j0_cnt      <= '0;
        j0_mismatch <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout       <= '0;
      dout_row   <= '0;
      dout_col   <= '0;
      dout_sof   <= 1'b0;
    end else begin
      dout_valid <= din_valid && sync;
      dout       <= dbyte;
      dout_row   <= row;
      dout_col   <= col;
      dout_sof   <= din_valid && sync && (row == '0) && (col == '0);
    end
  end

  // R9: a matching trace byte clears the flag
  p_j0_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (at_j0 && din == cfg_j0_expect) |=> !j0_mismatch);
  // R9: flag rises only on the third consecutive miss
  p_j0_third_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(j0_mismatch) |-> ($past(j0_cnt) == 2'd2));
  // R4: output bytes only from in-frame input
  p_out_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> !$past(oof));
endmodule

// File: tb/sonet_rx_framer_tb_top.sv
`timescale 1ns/1ps
module sonet_rx_framer_tb_top;
  localparam int ROWS = 9, COLS = 12, LOF_FRAMES = 3, CNT_W = 6;
  localparam int FB = ROWS * COLS;
  localparam int LOF_BYTES = LOF_FRAMES * FB;
  localparam logic [7:0] J0V = 8'h5A;

  logic clk = 0, rst = 1, din_valid = 0, b1_cnt_clr = 0;
  logic [7:0] din = 0, cfg_j0_expect = J0V;
  logic dout_valid, dout_sof, oof, lof, j0_mismatch;
  logic [7:0] dout;
  logic [$clog2(ROWS)-1:0] dout_row;
  logic [$clog2(COLS)-1:0] dout_col;
  logic [CNT_W-1:0] b1_err_cnt;

  int nchk = 0, nfail = 0;
  bit done = 0, gap_on = 0;
  logic [31:0] scb_q[$];
  logic [7:0] tx_bip = 0;
  logic [6:0] tx_s = '1;

  always #2.5 clk = ~clk;

  sonet_rx_framer #(.ROWS(ROWS), .COLS(COLS), .LOF_FRAMES(LOF_FRAMES), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
    .cfg_j0_expect(cfg_j0_expect), .b1_cnt_clr(b1_cnt_clr),
    .dout_valid(dout_valid), .dout(dout), .dout_row(dout_row), .dout_col(dout_col),
    .dout_sof(dout_sof), .oof(oof), .lof(lof), .j0_mismatch(j0_mismatch),
    .b1_err_cnt(b1_err_cnt));

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design emits them (R4, with R3 gaps)
  always @(negedge clk) begin
    if (!rst && dout_valid) begin
      if (scb_q.size() == 0) check("R4 unexpected output byte", 1, 0);
      else check("R4/R3 scoreboard byte,row,col,sof", int'({7'd0, dout_sof, 8'(dout_row), 8'(dout_col), dout}), int'(scb_q.pop_front()));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); din_valid = 0; end
  endtask

  task automatic send_byte(input logic [7:0] b);
    if (gap_on && $urandom_range(0, 3) == 0) idle(1);
    @(negedge clk);
    din_valid = 1;
    din = b;
  endtask

  // builds, scrambles and sends one frame; pushes plain bytes with index in [ps,pe)
  task automatic send_frame(input logic [7:0] a1v, input logic [7:0] j0v,
                            input logic [7:0] b1m, input int ps, input int pe);
    logic [7:0] plain, key, wb, acc;
    acc = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (r == 0 && c == 0)      plain = a1v;
        else if (r == 0 && c == 1) plain = 8'h28;
        else if (r == 0 && c == 2) plain = j0v;
        else if (r == 1 && c == 0) plain = tx_bip ^ b1m;
        else                       plain = 8'($urandom_range(0, 255));
        if (r == 0 && c == 3) tx_s = '1;
        for (int b = 7; b >= 0; b--) begin
          key[b] = tx_s[6];
          tx_s = {tx_s[5:0], tx_s[6] ^ tx_s[5]};
        end
        wb = (r == 0 && c < 3) ? plain : (plain ^ key);
        acc = acc ^ wb;
        if (r * COLS + c >= ps && r * COLS + c < pe)
          scb_q.push_back({7'd0, (r == 0 && c == 0), 8'(r), 8'(c), plain});
        send_byte(wb);
      end
    end
    tx_bip = acc;
  endtask

  initial begin
    #750us;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 oof after reset", oof, 1);
    check("R1 lof after reset", lof, 0);
    check("R1 j0_mismatch after reset", j0_mismatch, 0);
    check("R1 b1 count after reset", b1_err_cnt, 0);
    check("R1 dout_valid after reset", dout_valid, 0);

    for (int i = 0; i < 5; i++) send_byte(8'h00);
    send_frame(8'hF6, J0V, 0, FB, FB);
    idle(2);
    check("R2 single pattern keeps oof", oof, 1);
    gap_on = 1;
    send_frame(8'hF6, J0V, 0, 2, FB);
    idle(2);
    check("R2 second pattern clears oof", oof, 0);
    for (int f = 0; f < 3; f++) send_frame(8'hF6, J0V, 0, 0, FB);
    idle(2);
    check("R7 clean frames give no B1 errors", b1_err_cnt, 0);

    send_frame(8'hF6, J0V, 8'h05, 0, FB);
    idle(2);
    check("R7 two bit errors", b1_err_cnt, 2);
    send_frame(8'hF6, J0V, 8'h80, 0, FB);
    idle(2);
    check("R7 one more bit error", b1_err_cnt, 3);
    b1_cnt_clr = 1;
    idle(1);
    b1_cnt_clr = 0;
    idle(1);
    check("R8 clear zeroes counter", b1_err_cnt, 0);

    send_frame(8'hF6, 8'h11, 0, 0, FB);
    send_frame(8'hF6, 8'h11, 0, 0, FB);
    idle(2);
    check("R9 two misses keep flag low", j0_mismatch, 0);
    send_frame(8'hF6, 8'h11, 0, 0, FB);
    idle(2);
    check("R9 third miss raises flag", j0_mismatch, 1);
    send_frame(8'hF6, J0V, 0, 0, FB);
    idle(2);
    check("R9 match clears flag", j0_mismatch, 0);

    for (int f = 0; f < 7; f++) send_frame(8'hF6, J0V, 8'hFF, 0, FB);
    idle(2);
    check("R8 counting below limit", b1_err_cnt, 56);
    send_frame(8'hF6, J0V, 8'hFF, 0, FB);
    idle(2);
    check("R8 counter saturates", b1_err_cnt, 63);

    for (int f = 0; f < 3; f++) send_frame(8'h00, J0V, 0, 0, FB);
    idle(2);
    check("R5 three bad patterns keep frame", oof, 0);
    send_frame(8'hF6, J0V, 0, 0, FB);
    for (int f = 0; f < 3; f++) send_frame(8'h00, J0V, 0, 0, FB);
    idle(2);
    check("R5 interrupted run keeps frame", oof, 0);
    gap_on = 0;
    send_frame(8'h00, J0V, 0, 0, 2);
    idle(2);
    check("R5 fourth bad pattern raises oof", oof, 1);
    check("R6 no lof yet", lof, 0);
    for (int i = 0; i < LOF_BYTES - 1 - (FB - 2); i++) send_byte(8'h00);
    idle(2);
    check("R6 lof one byte before window", lof, 0);
    send_byte(8'h00);
    idle(2);
    check("R6 lof at end of window", lof, 1);
    check("R6 oof with lof", oof, 1);
    check("R4 no output while out of frame", dout_valid, 0);

    send_frame(8'hF6, J0V, 0, FB, FB);
    send_frame(8'hF6, J0V, 0, 2, FB);
    idle(2);
    check("R6 lof clears on reframe", lof, 0);
    check("R2 reframe clears oof", oof, 0);
    send_frame(8'hF6, J0V, 0, 0, FB);
    idle(4);
    check("R4 all expected bytes produced", scb_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule